// File: doc/BRIEF.md
# Command Queue Priority Aging

This block is a small command store for a memory controller. Each stored command carries a tag, a priority value and its own countdown counter. Lower priority values are more urgent. As a command waits, its priority value falls, so a command that has waited a long time is eventually chosen ahead of newer ones.

Aging runs at two levels. One shared rate generator completes a period every `age_count` active cycles. At the end of each period, every stored command's counter steps down by one. When a command's counter runs out, that command's priority value drops by one and its counter reloads with `cmd_age_count`. One priority step therefore takes `age_count * cmd_age_count` active cycles. Aging is active only when the enable bit is set and the placement-fill mode is on.

Commands enter through a push port and leave through a pop port that names a slot index. The block continuously reports every slot's state and the slot holding the most urgent command.

Top module: `cmdq_aging_top`

## Requirements
- R1: After reset, no slot is valid, `sel_valid` is 0 and `full` is 0.
- R2: A push goes into the lowest-index free slot and stores its tag and priority there. When all slots are valid, a push has no effect, even if a pop happens in the same cycle.
- R3: A pop of a valid slot clears that slot's valid bit on the next clock edge. A pop that names an invalid slot changes nothing.
- R4: `sel_idx` names the valid slot with the lowest priority value, and ties go to the lowest index. `sel_valid` is 0 when no slot is valid.
- R5: With aging active from reset, a command pushed while aging was inactive first drops its priority value by one after exactly `age_count*cmd_age_count` active cycles. The next drop comes after the same number again. All stored commands age together.
- R6: An `age_count` or `cmd_age_count` of 0 acts as 1, so with both at 0 the priority value drops on every active cycle.
- R7: A priority value saturates at 0 and never wraps.
- R8: Aging is active only when `aging_en`=1 and `place_mode`=1. While inactive, the rate generator and all per-command counters hold their values, and aging resumes from where it stopped.
- R9: A push loads that slot's counter with the full `cmd_age_count`. A slot reused after a pop carries over none of the old command's aging progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Store a new command this cycle |
| push_tag | input | TAG_W (8) | Tag of the new command |
| push_prio | input | PRIO_W (4) | Starting priority value of the new command |
| pop_valid | input | 1 | Remove the command at `pop_idx` |
| pop_idx | input | IDX_W (3) | Slot to remove |
| age_count | input | AGE_W (8) | Rate generator period in cycles (0 acts as 1) |
| cmd_age_count | input | AGE_W (8) | Per-command reload count in periods (0 acts as 1) |
| aging_en | input | 1 | 1 enables aging |
| place_mode | input | 1 | 1 when the placement logic fills the queue |
| entry_valid | output | DEPTH (8) | Valid bit per slot, bit i for slot i |
| entry_prio | output | DEPTH*PRIO_W (32) | Priority of slot i in bits [i*4 +: 4] |
| entry_tag | output | DEPTH*TAG_W (64) | Tag of slot i in bits [i*8 +: 8] |
| sel_valid | output | 1 | At least one slot is valid |
| sel_idx | output | IDX_W (3) | Most urgent valid slot |
| full | output | 1 | All slots are valid |

## Verification
Aging is exercised with four parameter pairs, and each pair separates a different class of bug:
- **3×2:** the priority is checked one active cycle before the product and again at the product. This exposes a sum-instead-of-product error and any off-by-one in either counter.
- **0×0:** shows whether a zero parameter stalls aging or wraps to a long period.
- **1×1 on a priority of 1:** shows whether the value wraps below 0.
- **1×4 on a reused slot:** shows whether a new command inherits the old command's aging progress.

Activity gating is tried in three ways: with the enable dropped, with the placement mode dropped, and with both held off part-way through a period. This shows that both counters freeze rather than reset. Selection is tried with ties, with pops that move the winner, and with an empty queue.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  // Zero parameter values behave as one
  function automatic logic [15:0] floor_one(input logic [15:0] v);
    return (v == 16'd0) ? 16'd1 : v;
  endfunction

  // Decrement that stops at zero
  function automatic logic [15:0] sat_dec(input logic [15:0] v);
    return (v == 16'd0) ? 16'd0 : v - 16'd1;
  endfunction

endpackage

// File: rtl/cmdq_rate_gen.sv
module cmdq_rate_gen #(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [AGE_W-1:0] age_count,
  output logic             tick
);
  logic [AGE_W-1:0] mcnt;
  logic [AGE_W-1:0] period;
  logic [AGE_W-1:0] last;
  logic             at_end;

  assign period = AGE_W'(cmdq_pkg::floor_one(16'(age_count)));
  assign last   = period - AGE_W'(1);
  assign at_end = (mcnt >= last);
  assign tick   = active && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= '0;
    end else if (active) begin
      mcnt <= at_end ? '0 : mcnt + AGE_W'(1);
    end
  end

  // R8
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(mcnt));

  // R5
  rate_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (mcnt == '0));

endmodule

// File: rtl/cmdq_entry.sv
module cmdq_entry #(
  parameter int PRIO_W = 4,
  parameter int AGE_W  = 8,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [PRIO_W-1:0] load_prio,
  input  logic [AGE_W-1:0]  cmd_period,
  input  logic              clear,
  input  logic              tick,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [PRIO_W-1:0] prio,
  output logic              step
);
  logic [AGE_W-1:0] cnt;

  assign step = valid && tick && (cnt <= AGE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      prio  <= '0;
      cnt   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      tag   <= load_tag;
      prio  <= load_prio;
      cnt   <= cmd_period;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (valid && tick) begin
      if (cnt <= AGE_W'(1)) begin
        cnt  <= cmd_period;
        prio <= PRIO_W'(cmdq_pkg::sat_dec(16'(prio)));
      end else begin
        cnt <= cnt - AGE_W'(1);
      end
    end
  end

  // R7
  prio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && prio == '0 && !load) |=> (prio == '0));

  // R5
  prio_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !load) |=> (prio <= $past(prio)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !tick && !load && !clear) |=> ($stable(prio) && $stable(cnt)));

  // R9
  load_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid && cnt == $past(cmd_period)));

endmodule

// File: rtl/cmdq_pick.sv
module cmdq_pick #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic [DEPTH-1:0]        valid,
  input  logic [DEPTH*PRIO_W-1:0] prio_flat,
  output logic                    sel_valid,
  output logic [IDX_W-1:0]        sel_idx,
  output logic [PRIO_W-1:0]       sel_prio
);
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_prio  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      // Strict compare keeps the lower index on a tie
      if (valid[i] && (!sel_valid || prio_flat[i*PRIO_W +: PRIO_W] < sel_prio)) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        sel_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cmdq_aging_top.sv
module cmdq_aging_top #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 4,
  parameter int AGE_W  = 8,
  parameter int TAG_W  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_valid,
  input  logic [TAG_W-1:0]        push_tag,
  input  logic [PRIO_W-1:0]       push_prio,
  input  logic                    pop_valid,
  input  logic [IDX_W-1:0]        pop_idx,
  input  logic [AGE_W-1:0]        age_count,
  input  logic [AGE_W-1:0]        cmd_age_count,
  input  logic                    aging_en,
  input  logic                    place_mode,
  output logic [DEPTH-1:0]        entry_valid,
  output logic [DEPTH*PRIO_W-1:0] entry_prio,
  output logic [DEPTH*TAG_W-1:0]  entry_tag,
  output logic                    sel_valid,
  output logic [IDX_W-1:0]        sel_idx,
  output logic                    full
);
  logic             active;
  logic             tick;
  logic [AGE_W-1:0] cmd_period;
  logic [IDX_W-1:0] free_idx;
  logic             push_do;
  logic             pop_in_range;
  logic             pop_do;
  logic [DEPTH-1:0] step_vec;
  logic [PRIO_W-1:0] sel_prio;

  assign active     = aging_en && place_mode;
  assign cmd_period = AGE_W'(cmdq_pkg::floor_one(16'(cmd_age_count)));
  assign full       = &entry_valid;
  assign push_do    = push_valid && !full;
  assign pop_in_range = (32'(pop_idx) < DEPTH);
  assign pop_do     = pop_valid && pop_in_range && entry_valid[pop_idx];

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!entry_valid[i]) free_idx = IDX_W'(i);
    end
  end

  cmdq_rate_gen #(.AGE_W(AGE_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .age_count (age_count),
    .tick      (tick)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    cmdq_entry #(.PRIO_W(PRIO_W), .AGE_W(AGE_W), .TAG_W(TAG_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (push_do && free_idx == IDX_W'(g)),
      .load_tag   (push_tag),
      .load_prio  (push_prio),
      .cmd_period (cmd_period),
      .clear      (pop_do && pop_idx == IDX_W'(g)),
      .tick       (tick),
      .valid      (entry_valid[g]),
      .tag        (entry_tag[g*TAG_W +: TAG_W]),
      .prio       (entry_prio[g*PRIO_W +: PRIO_W]),
      .step       (step_vec[g])
    );

    // R4
    pick_is_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid[g] |-> (entry_prio[g*PRIO_W +: PRIO_W] >= sel_prio));
  end

  cmdq_pick #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .valid     (entry_valid),
    .prio_flat (entry_prio),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sel_prio  (sel_prio)
  );

  // R4
  pick_points_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> entry_valid[sel_idx]);

  // R3
  pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_do |=> !entry_valid[$past(pop_idx)]);

  // R2
  full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop_valid) |=> $stable(entry_valid));

  // R2
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_do |=> entry_valid[$past(free_idx)]);

  // R8
  no_step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (step_vec == '0));

endmodule

// File: tb/cmdq_aging_top_bench.sv
module cmdq_aging_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_valid;
  logic [7:0] push_tag;
  logic [3:0] push_prio;
  logic       pop_valid;
  logic [2:0] pop_idx;
  logic [7:0] age_count;
  logic [7:0] cmd_age_count;
  logic       aging_en;
  logic       place_mode;
  logic [7:0]  entry_valid;
  logic [31:0] entry_prio;
  logic [63:0] entry_tag;
  logic        sel_valid;
  logic [2:0]  sel_idx;
  logic        full;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_aging_top u_cmdq_aging_top (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_tag(push_tag), .push_prio(push_prio),
    .pop_valid(pop_valid), .pop_idx(pop_idx),
    .age_count(age_count), .cmd_age_count(cmd_age_count),
    .aging_en(aging_en), .place_mode(place_mode),
    .entry_valid(entry_valid), .entry_prio(entry_prio), .entry_tag(entry_tag),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .full(full)
  );

  function automatic int pr(input int i);
    return int'(entry_prio[i*4 +: 4]);
  endfunction

  function automatic int tg(input int i);
    return int'(entry_tag[i*8 +: 8]);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int ac, input int cc);
    @(negedge clk);
    rst_n = 1'b0;
    push_valid = 0; push_tag = 0; push_prio = 0;
    pop_valid = 0; pop_idx = 0;
    aging_en = 0; place_mode = 1;
    age_count = 8'(ac); cmd_age_count = 8'(cc);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input int t, input int p);
    push_valid = 1'b1; push_tag = 8'(t); push_prio = 4'(p);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop(input int idx);
    pop_valid = 1'b1; pop_idx = 3'(idx);
    @(negedge clk);
    pop_valid = 1'b0;
  endtask

  // n clock edges with the given enable and mode, then aging off again
  task automatic run(input int n, input logic en, input logic pm);
    aging_en = en; place_mode = pm;
    repeat (n) @(posedge clk);
    @(negedge clk);
    aging_en = 1'b0; place_mode = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1, 1);
    check("R1", "valid", int'(entry_valid), 0);
    check("R1", "sel_valid", int'(sel_valid), 0);
    check("R1", "full", int'(full), 0);
  endtask

  task automatic t_fill();
    do_reset(1, 1);
    for (int i = 0; i < 8; i++) push(16 + i, 8 - i);
    check("R2", "valid after 8 pushes", int'(entry_valid), 255);
    check("R2", "full", int'(full), 1);
    check("R2", "tag slot3", tg(3), 19);
    check("R2", "prio slot3", pr(3), 5);
    push(238, 0);
    check("R2", "valid after push when full", int'(entry_valid), 255);
    check("R2", "tag slot7 kept", tg(7), 23);
    // pop and push together while full: push dropped
    pop_valid = 1'b1; pop_idx = 3'd2; push_valid = 1'b1; push_tag = 8'd99; push_prio = 4'd1;
    @(negedge clk);
    pop_valid = 1'b0; push_valid = 1'b0;
    check("R2", "pop+push while full", int'(entry_valid), 251);
    pop(2);
    check("R3", "pop of empty slot", int'(entry_valid), 251);
    push(77, 3);
    check("R2", "refill lowest free", int'(entry_valid), 255);
    check("R2", "tag slot2", tg(2), 77);
  endtask

  task automatic t_select();
    do_reset(1, 1);
    push(1, 7); push(2, 3); push(3, 3); push(4, 9);
    check("R4", "sel on tie", int'(sel_idx), 1);
    check("R4", "sel_valid", int'(sel_valid), 1);
    pop(1);
    check("R3", "slot1 cleared", int'(entry_valid), 13);
    check("R4", "sel after pop1", int'(sel_idx), 2);
    pop(2);
    check("R4", "sel after pop2", int'(sel_idx), 0);
    push(5, 7);
    check("R4", "tie lower index", int'(sel_idx), 0);
    pop(0); pop(1); pop(3);
    check("R4", "empty sel_valid", int'(sel_valid), 0);
  endtask

  task automatic t_rate();
    do_reset(3, 2);
    push(1, 8); push(2, 5);
    run(5, 1, 1);
    check("R5", "no drop at 5", pr(0), 8);
    run(1, 1, 1);
    check("R5", "drop at 6 slot0", pr(0), 7);
    check("R5", "drop at 6 slot1", pr(1), 4);
    run(5, 1, 1);
    check("R5", "no drop at 11", pr(0), 7);
    run(1, 1, 1);
    check("R5", "second drop at 12", pr(0), 6);
  endtask

  task automatic t_zero();
    do_reset(0, 0);
    push(1, 9);
    run(3, 1, 1);
    check("R6", "zero params", pr(0), 6);
  endtask

  task automatic t_floor();
    do_reset(1, 1);
    push(1, 1);
    run(3, 1, 1);
    check("R7", "saturate", pr(0), 0);
    check("R7", "still valid", int'(entry_valid), 1);
  endtask

  task automatic t_hold();
    do_reset(2, 2);
    push(1, 10);
    run(3, 1, 1);
    run(10, 1, 0);
    check("R8", "mode off holds", pr(0), 10);
    run(10, 0, 1);
    check("R8", "enable off holds", pr(0), 10);
    run(1, 1, 1);
    check("R8", "resumes", pr(0), 9);
  endtask

  task automatic t_fresh();
    do_reset(1, 4);
    push(1, 12);
    run(2, 1, 1);
    pop(0);
    push(2, 5);
    check("R9", "reuse slot0 tag", tg(0), 2);
    run(3, 1, 1);
    check("R9", "fresh count no drop", pr(0), 5);
    run(1, 1, 1);
    check("R9", "drop after full count", pr(0), 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_fill();
    t_select();
    t_rate();
    t_zero();
    t_floor();
    t_hold();
    t_fresh();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule